// File: doc/BRIEF.md
# Clock Alarm Interrupt Status Unit

This block is the byte-wide register window of a telecom clock controller that sits beside an external synchronizing PLL. It watches four asynchronous alarm levels from that PLL (primary reference lost, secondary reference lost, holdover, unlock). It also watches one level that tells which reference is active. Each alarm input passes through a synchronizer. Every transition of an alarm is then latched into its own cause bit: one bit for a 0-to-1 change and one bit for a 1-to-0 change. The latched cause bits drive a level interrupt.

Software reaches the block through a simple 3-bit-address byte bus. Reading the cause byte returns the latched transitions and empties them. A second byte reports the live alarm levels next to four clock output enables. Further control fields set the PLL mode, the hardware switchover policy and the redundant reference. These fields go straight to output pins. Writing a one into the align field while it holds zero produces a single-cycle align strobe. A fixed interrupt line number can be read back so that software can probe for the block.

Top module: `clk_alarm_irq_unit`

## Requirements
- R1: After reset every cause bit, `irq_o`, `align_pulse_o`, the clock enables and every control field read as zero.
- R2: A change of an alarm input sets its cause bit at offset 6 on the third rising clock edge after the change, and the bit stays set until it is read. The cause bits are: primary lost 0-to-1 = bit0, primary lost 1-to-0 = bit1, secondary lost 0-to-1 = bit2, secondary lost 1-to-0 = bit3, holdover 0-to-1 = bit4, holdover 1-to-0 = bit5, unlock 0-to-1 = bit6, unlock 1-to-0 = bit7.
- R3: A read of offset 6 returns the accumulated cause bits on `rdata` in that cycle and clears them at the next clock edge.
- R4: A transition whose cause bit would be set on the same edge as a clearing read of offset 6 stays set after the clear.
- R5: `irq_o` is high exactly while any cause bit is set, and it falls only after a read of offset 6.
- R6: Offset 2 bits 7:4 return the synchronized live levels (bit7 primary lost, bit6 secondary lost, bit5 holdover, bit4 unlock). These bits are read-only, and writes to them have no effect.
- R7: Offset 2 bits 3:0 are four writable clock output enables that read back and drive `clk_out_en_o[3:0]`.
- R8: Offset 1 bit 0 is the writable redundant reference select driving `ref_sel_o`. Offset 1 bit 3 reads the synchronized `active_ref_i` level and cannot be written.
- R9: Offset 0 bits 5:4 hold the PLL mode (00 normal, 01 holdover, 10 free-run) driving `pll_mode_o`. Bit 7 holds the hardware switchover enable (`hw_switch_en_o`). Bit 6 holds the switchover trigger (`switch_on_holdover_o`: 1 = holdover, 0 = lost clock). All three fields read back.
- R10: Writing offset 0 with bit 3 = 1 while the stored align bit is 0 raises `align_pulse_o` for exactly one cycle, starting after the write edge. A write with bit 3 = 1 while the bit is already 1 gives no pulse.
- R11: Offset 7 reads the `IRQ_LINE` parameter in bits 3:0 and zeros above. The value 0xF is rejected at elaboration, and writes to offset 7 are ignored.
- R12: Offsets 3, 4 and 5 and all unassigned bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register byte offset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle (read of offset 6 clears it) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pri_lost_i | input | 1 | Asynchronous primary reference lost level |
| sec_lost_i | input | 1 | Asynchronous secondary reference lost level |
| holdover_i | input | 1 | Asynchronous PLL holdover level |
| unlock_i | input | 1 | Asynchronous PLL unlock level |
| active_ref_i | input | 1 | Asynchronous active reference indication |
| irq_o | output | 1 | Level interrupt, high while any cause bit is set |
| pll_mode_o | output | 2 | PLL mode field |
| hw_switch_en_o | output | 1 | Hardware switchover enable |
| switch_on_holdover_o | output | 1 | Switchover trigger select |
| ref_sel_o | output | 1 | Redundant reference select |
| clk_out_en_o | output | 4 | Clock output enables |
| align_pulse_o | output | 1 | One-cycle reference align strobe |

## Verification
The assertions assume that an alarm input holds each level long enough to pass the two-flop synchronizer and be seen as a clean edge. They also assume that `rd_en` and `wr_en` are never high together. The random stimulus changes the alarm levels only once every several cycles and runs its bus accesses one at a time, so both assumptions hold. The directed cases place one alarm transition exactly on the clearing read edge, and they write to every read-only bit and to offset 7.

// File: rtl/clk_alarm_pkg.sv
package clk_alarm_pkg;
   localparam int BYTE_W   = 8;
   localparam int OFS_W    = 3;
   localparam int ALARM_N  = 4;

   localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd0;
   localparam logic [OFS_W-1:0] OFS_REF    = 3'd1;
   localparam logic [OFS_W-1:0] OFS_LEVEL  = 3'd2;
   localparam logic [OFS_W-1:0] OFS_CAUSE  = 3'd6;
   localparam logic [OFS_W-1:0] OFS_IDENT  = 3'd7;

   localparam int CTRL_HWSW_BIT  = 7;
   localparam int CTRL_TRIG_BIT  = 6;
   localparam int CTRL_MODE_LSB  = 4;
   localparam int CTRL_ALIGN_BIT = 3;
   localparam int REF_ACT_BIT    = 3;
   localparam int REF_SEL_BIT    = 0;

   typedef enum logic [1:0] {
      PLL_NORMAL   = 2'b00,
      PLL_HOLDOVER = 2'b01,
      PLL_FREERUN  = 2'b10
   } pll_mode_e;

   typedef struct packed {
      logic       hw_switch_en;
      logic       switch_on_holdover;
      logic [1:0] mode;
      logic       align;
   } ctrl_fields_t;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("alarm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("alarm_sync: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/alarm_edge_cause.sv
module alarm_edge_cause #(
   parameter int N_ALARM = 4,
   localparam int CAUSE_W = 2 * N_ALARM
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_ALARM-1:0] lvl_i,
   input  logic               clr_i,
   output logic [CAUSE_W-1:0] evt_o,
   output logic [CAUSE_W-1:0] cause_o
);
   logic [N_ALARM-1:0] prev_q;
   logic [CAUSE_W-1:0] cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   for (genvar i = 0; i < N_ALARM; i++) begin : g_pair
      assign evt_o[2*i]   =  lvl_i[i] & ~prev_q[i];
      assign evt_o[2*i+1] = ~lvl_i[i] &  prev_q[i];
   end

   // a clearing read wipes old bits, fresh events still land
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (clr_i ? '0 : cause_q) | evt_o;
   end

   assign cause_o = cause_q;
endmodule

// File: rtl/alarm_ctrl_regs.sv
module alarm_ctrl_regs
   import clk_alarm_pkg::*;
#(
   parameter int N_CLKOUT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [OFS_W-1:0]    addr,
   input  logic                wr_en,
   input  logic [BYTE_W-1:0]   wdata,
   output ctrl_fields_t        ctrl_o,
   output logic                ref_sel_o,
   output logic [N_CLKOUT-1:0] clk_en_o,
   output logic                align_pulse_o
);
   if (N_CLKOUT > CTRL_ALIGN_BIT + 1) begin : g_bad_clkout
      $error("alarm_ctrl_regs: enables must fit below the level nibble");
   end

   ctrl_fields_t        ctrl_q;
   logic                ref_sel_q;
   logic [N_CLKOUT-1:0] clk_en_q;
   logic                pulse_q;
   logic                wr_ctrl, wr_ref, wr_lvl;

   assign wr_ctrl = wr_en && (addr == OFS_CTRL);
   assign wr_ref  = wr_en && (addr == OFS_REF);
   assign wr_lvl  = wr_en && (addr == OFS_LEVEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.hw_switch_en       <= wdata[CTRL_HWSW_BIT];
         ctrl_q.switch_on_holdover <= wdata[CTRL_TRIG_BIT];
         ctrl_q.mode               <= wdata[CTRL_MODE_LSB +: 2];
         ctrl_q.align              <= wdata[CTRL_ALIGN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ref_sel_q <= 1'b0;
      else if (wr_ref) ref_sel_q <= wdata[REF_SEL_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      clk_en_q <= '0;
      else if (wr_lvl) clk_en_q <= wdata[N_CLKOUT-1:0];
   end

   // strobe only on a 0 -> 1 change of the stored align bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= wr_ctrl && wdata[CTRL_ALIGN_BIT] && !ctrl_q.align;
   end

   assign ctrl_o        = ctrl_q;
   assign ref_sel_o     = ref_sel_q;
   assign clk_en_o      = clk_en_q;
   assign align_pulse_o = pulse_q;
endmodule

// File: rtl/clk_alarm_irq_unit.sv
module clk_alarm_irq_unit
   import clk_alarm_pkg::*;
#(
   parameter int IRQ_LINE    = 5,
   parameter int SYNC_STAGES = 2,
   parameter int N_CLKOUT    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          addr,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [7:0]          wdata,
   output logic [7:0]          rdata,
   input  logic                pri_lost_i,
   input  logic                sec_lost_i,
   input  logic                holdover_i,
   input  logic                unlock_i,
   input  logic                active_ref_i,
   output logic                irq_o,
   output logic [1:0]          pll_mode_o,
   output logic                hw_switch_en_o,
   output logic                switch_on_holdover_o,
   output logic                ref_sel_o,
   output logic [N_CLKOUT-1:0] clk_out_en_o,
   output logic                align_pulse_o
);
   localparam int CAUSE_W = 2 * ALARM_N;
   localparam int SYNC_W  = ALARM_N + 1;
   localparam int LVL_LSB = BYTE_W - ALARM_N;

   if (IRQ_LINE < 0 || IRQ_LINE > 14) begin : g_bad_irq_line
      $error("clk_alarm_irq_unit: IRQ_LINE must be 0..14, 15 marks absence");
   end
   if (N_CLKOUT != 4) begin : g_bad_clkout
      $error("clk_alarm_irq_unit: the level byte carries exactly four enables");
   end

   logic [SYNC_W-1:0]  raw_in, sync_lvl;
   logic [ALARM_N-1:0] alarm_lvl;
   logic               act_ref;
   logic [CAUSE_W-1:0] evt_vec, cause_q;
   logic               rd_clr;
   ctrl_fields_t       ctrl;
   logic [BYTE_W-1:0]  rd_ctrl, rd_ref, rd_lvl, rd_ident;
   logic [ALARM_N-1:0] lvl_nibble;

   // index order: 0 primary, 1 secondary, 2 holdover, 3 unlock, 4 active ref
   assign raw_in = {active_ref_i, unlock_i, holdover_i, sec_lost_i, pri_lost_i};

   alarm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_in),
      .sync_o  (sync_lvl)
   );

   assign alarm_lvl = sync_lvl[ALARM_N-1:0];
   assign act_ref   = sync_lvl[ALARM_N];
   assign rd_clr    = rd_en && (addr == OFS_CAUSE);

   alarm_edge_cause #(.N_ALARM(ALARM_N)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (alarm_lvl),
      .clr_i   (rd_clr),
      .evt_o   (evt_vec),
      .cause_o (cause_q)
   );

   alarm_ctrl_regs #(.N_CLKOUT(N_CLKOUT)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .addr          (addr),
      .wr_en         (wr_en),
      .wdata         (wdata),
      .ctrl_o        (ctrl),
      .ref_sel_o     (ref_sel_o),
      .clk_en_o      (clk_out_en_o),
      .align_pulse_o (align_pulse_o)
   );

   // level nibble runs from primary at the top down to unlock
   for (genvar k = 0; k < ALARM_N; k++) begin : g_lvl_rev
      assign lvl_nibble[ALARM_N-1-k] = alarm_lvl[k];
   end

   always_comb begin
      rd_ctrl = '0;
      rd_ctrl[CTRL_HWSW_BIT]         = ctrl.hw_switch_en;
      rd_ctrl[CTRL_TRIG_BIT]         = ctrl.switch_on_holdover;
      rd_ctrl[CTRL_MODE_LSB +: 2]    = ctrl.mode;
      rd_ctrl[CTRL_ALIGN_BIT]        = ctrl.align;
      rd_ref = '0;
      rd_ref[REF_ACT_BIT]            = act_ref;
      rd_ref[REF_SEL_BIT]            = ref_sel_o;
      rd_lvl   = {lvl_nibble, clk_out_en_o};
      rd_ident = '0;
      rd_ident[3:0]                  = 4'(IRQ_LINE);
   end

   always_comb begin
      unique case (addr)
         OFS_CTRL:  rdata = rd_ctrl;
         OFS_REF:   rdata = rd_ref;
         OFS_LEVEL: rdata = rd_lvl;
         OFS_CAUSE: rdata = cause_q;
         OFS_IDENT: rdata = rd_ident;
         default:   rdata = '0;
      endcase
   end

   assign irq_o                = |cause_q;
   assign pll_mode_o           = ctrl.mode;
   assign hw_switch_en_o       = ctrl.hw_switch_en;
   assign switch_on_holdover_o = ctrl.switch_on_holdover;
endmodule

// File: rtl/clk_alarm_irq_chk.sv
module clk_alarm_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] addr,
   input logic       rd_en,
   input logic [7:0] rdata,
   input logic       irq_o,
   input logic       align_pulse_o,
   input logic [7:0] evt_vec,
   input logic [7:0] cause_q
);
   logic rd_clr;
   assign rd_clr = rd_en && (addr == 3'd6);

   // R2: cause bits stay set while no clearing read happens
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

   // R3: a clearing read with no coincident event empties the register
   p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && evt_vec == 8'h00) |=> (cause_q == 8'h00));

   // R4: events coinciding with the clear are kept
   p_keep_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> ((cause_q & $past(evt_vec)) == $past(evt_vec)));

   // R5: the interrupt only drops after a clearing read
   p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(rd_clr));

   // R10: the align strobe lasts one cycle
   p_align_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      align_pulse_o |=> !align_pulse_o);

   // R11: the identity nibble never reads as absent
   p_ident_present_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 3'd7) |-> (rdata[3:0] != 4'hF));
endmodule

bind clk_alarm_irq_unit clk_alarm_irq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .addr          (addr),
   .rd_en         (rd_en),
   .rdata         (rdata),
   .irq_o         (irq_o),
   .align_pulse_o (align_pulse_o),
   .evt_vec       (evt_vec),
   .cause_q       (cause_q)
);

// File: tb/clk_alarm_irq_unit_test.sv
`timescale 1ns/1ps
module clk_alarm_irq_unit_test;
   localparam int LINE = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] alarm = '0;   // 0 pri, 1 sec, 2 holdover, 3 unlock
   logic       act_ref = 1'b0;
   logic       irq_o, hw_sw, trig, ref_sel, align_p;
   logic [1:0] mode;
   logic [3:0] clk_en;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_cause = '0;

   always #2.5 clk = ~clk;

   clk_alarm_irq_unit #(.IRQ_LINE(LINE)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata),
      .pri_lost_i(alarm[0]), .sec_lost_i(alarm[1]), .holdover_i(alarm[2]),
      .unlock_i(alarm[3]), .active_ref_i(act_ref),
      .irq_o(irq_o), .pll_mode_o(mode), .hw_switch_en_o(hw_sw),
      .switch_on_holdover_o(trig), .ref_sel_o(ref_sel),
      .clk_out_en_o(clk_en), .align_pulse_o(align_p)
   );

   function automatic logic [7:0] edges(input logic [3:0] was, input logic [3:0] now);
      logic [7:0] e = '0;
      for (int i = 0; i < 4; i++) begin
         e[2*i]   = now[i] & ~was[i];
         e[2*i+1] = ~now[i] & was[i];
      end
      return e;
   endfunction

   function automatic logic [3:0] level_nibble(input logic [3:0] a);
      logic [3:0] n;
      for (int i = 0; i < 4; i++) n[3-i] = a[i];
      return n;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle(input logic [3:0] nxt);
      @(negedge clk);
      exp_cause = exp_cause | edges(alarm, nxt);
      alarm = nxt;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int seed;
      seed = $urandom(32'd20240611);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", irq_o, 0);
      check("R1 outputs", {mode, hw_sw, trig, ref_sel, clk_en, align_p}, 0);
      bus_read(3'd6, d); check("R1 cause", d, 8'h00);
      bus_read(3'd0, d); check("R1 ctrl", d, 8'h00);

      // R11 identity and ignored write
      bus_write(3'd7, 8'hFF);
      bus_read(3'd7, d); check("R11 ident", d, 8'(LINE));

      // R12 spare offsets
      for (int o = 3; o <= 5; o++) begin
         bus_write(3'(o), 8'hFF);
         bus_read(3'(o), d); check("R12 spare offset", d, 8'h00);
      end

      // R9 control fields
      bus_write(3'd0, 8'hE0);
      check("R9 outputs", {hw_sw, trig, mode}, 4'b1110);
      bus_read(3'd0, d); check("R9 readback", d, 8'hE0);
      bus_write(3'd0, 8'h10);
      check("R9 holdover mode", {hw_sw, trig, mode}, 4'b0001);

      // R10 align strobe
      bus_write(3'd0, 8'h18);
      check("R10 pulse high", align_p, 1);
      @(negedge clk); check("R10 pulse one cycle", align_p, 0);
      bus_write(3'd0, 8'h18);
      check("R10 no pulse when already set", align_p, 0);
      bus_write(3'd0, 8'h10);
      bus_write(3'd0, 8'h18);
      check("R10 pulse after 0 then 1", align_p, 1);

      // R8 reference select / active ref
      bus_write(3'd1, 8'hFF);
      check("R8 ref_sel", ref_sel, 1);
      bus_read(3'd1, d); check("R8 readback, active bit not writable", d, 8'h01);
      act_ref = 1'b1; repeat (4) @(negedge clk);
      bus_read(3'd1, d); check("R8 active ref", d, 8'h09);

      // R7 / R6 enables and read-only levels
      bus_write(3'd2, 8'hF5);
      check("R7 enables", clk_en, 4'h5);
      bus_read(3'd2, d); check("R6 upper ignores write, R7 lower", d, 8'h05);

      // R2 exact timing: set lands on third edge
      @(negedge clk); alarm[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R2 not yet at second edge", irq_o, 0);
      @(negedge clk);
      check("R2 set after third edge", irq_o, 1);
      exp_cause = 8'h01;
      bus_read(3'd2, d); check("R6 primary level", d, 8'h85);
      bus_read(3'd6, d); check("R3 read value", d, 8'h01);
      check("R5 irq drops after read", irq_o, 0);
      bus_read(3'd6, d); check("R3 cleared", d, 8'h00);
      exp_cause = '0;

      // R4 event on the clearing edge
      settle(4'b1001);               // unlock rises
      check("R2 unlock rise", {irq_o, exp_cause}, {1'b1, 8'h40});
      @(negedge clk); alarm[1] = 1'b1;   // secondary rises, lands on 3rd edge
      @(negedge clk); @(negedge clk);
      addr = 3'd6; rd_en = 1'b1;
      #1 d = rdata;
      check("R3 value before coincident clear", d, 8'h40);
      @(negedge clk); rd_en = 1'b0;
      check("R4 irq held by coincident event", irq_o, 1);
      bus_read(3'd6, d); check("R4 coincident bit kept", d, 8'h04);
      exp_cause = '0;

      // R2/R3/R5/R6 random phase
      for (int it = 0; it < 400; it++) begin
         logic [3:0] nxt;
         nxt = 4'($urandom);
         settle(nxt);
         check("R5 irq level", irq_o, exp_cause != 0);
         if (($urandom % 3) == 0) begin
            bus_read(3'd6, d); check("R2 random cause", d, exp_cause);
            exp_cause = '0;
            check("R5 irq after read", irq_o, 0);
         end
         if (($urandom % 5) == 0) begin
            bus_read(3'd2, d); check("R6 random levels", d, {level_nibble(alarm), 4'h5});
         end
      end
      bus_read(3'd6, d); check("R2 final cause", d, exp_cause);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule